// File: doc/BRIEF.md
# Dual-Polarity Phase Detector With Lock Indicator

This block compares a divided reference pulse train against a divided feedback pulse train and tells the loop which of the two is ahead. It works in a single system clock domain: both pulse inputs are sampled on the rising edge of `clk` and only their rising edges matter. An internal up/down state machine arms "up" when the reference edge comes first and "down" when the feedback edge comes first. It returns to idle in the cycle that the other edge arrives.

The block drives two charge-pump control outputs of opposite sense. Each is modelled as a data bit plus an output enable, so the three-state pad can live outside this block. While an error is pending both outputs are enabled and drive opposite levels. Otherwise both float. A raw lock line is low for exactly the cycles of the phase error. A filtered lock flag rises only after a run of consecutive comparisons whose error width stayed below a programmable threshold.

Top module: `phase_det_lock`

## Requirements
- R1: While `rst` is high, and after it is released with no input edge, both enables are 0, both data bits are 0, `ldt` is 1 and `lock_ok` is 0.
- R2: A rising edge of `fr_in`, sampled at a clock edge with no error pending, makes both enables 1 from that edge onward, with `pdp_drv` = 1 and `pda_drv` = 0, until a feedback edge is sampled.
- R3: A rising edge of `fn_in` with no error pending gives the opposite drive: both enables 1, `pda_drv` = 1 and `pdp_drv` = 0.
- R4: A pending error ends at the clock edge that samples the opposite input's rising edge: both enables return to 0 at that edge. The error therefore lasts exactly the number of clock cycles between the two sampled edges.
- R5: Rising edges of `fr_in` and `fn_in` sampled at the same clock edge produce no drive pulse and leave `ldt` at 1.
- R6: Another rising edge of the leading input while its error is pending changes nothing. A single edge of the other input still ends the error, and no error of the other sense is left behind.
- R7: `pda_oe` always equals `pdp_oe`. Whenever the enables are 0, both data bits are 0.
- R8: `ldt` is 0 exactly during the cycles in which the enables are 1.
- R9: `lock_ok` becomes 1 at the clock edge that ends the LOCK_CYCLES-th consecutive comparison whose error width is below ERR_THRESH cycles. A comparison from coincident edges counts, with width 0.
- R10: An error that has lasted ERR_THRESH cycles clears the run of good comparisons. `lock_ok` drops at that edge even if the error is still pending.
- R11: An input held high produces one edge only. A level that stays high does not start a new comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all sampling on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fr_in | input | 1 | Divided reference pulse train |
| fn_in | input | 1 | Divided feedback pulse train |
| pda_drv | output | 1 | Data bit for the first charge-pump output (low when reference leads) |
| pda_oe | output | 1 | Enable for the first charge-pump output |
| pdp_drv | output | 1 | Data bit for the second charge-pump output (high when reference leads) |
| pdp_oe | output | 1 | Enable for the second charge-pump output |
| ldt | output | 1 | Raw lock line, low while a phase error is pending |
| lock_ok | output | 1 | Filtered lock flag |

## Verification
The bench looks for several wrong behaviours:
- Coincident edges: a detector that arms one side before clearing would show a one-cycle glitch on the enables and on `ldt`.
- Repeated edges from the leading input: a design that counts them would either stay armed after the single opposite edge or leave a stale error of the wrong sense.
- A level held high on an input: a design that reacts to levels rather than edges would re-arm on every cycle.
- The lock filter at exactly ERR_THRESH-1 and ERR_THRESH cycles of error, and during an unresolved long error: an off-by-one in the width count would keep `lock_ok` high one cycle too long or drop it for a legal pulse.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;

    typedef enum logic [1:0] {
        PD_IDLE = 2'd0,
        PD_UP   = 2'd1,
        PD_DN   = 2'd2
    } pd_state_e;

    typedef struct packed {
        logic drv;
        logic oe;
    } tri_drv_t;

    // Drive for one charge-pump output. lead_high selects the level used
    // when the reference is ahead; the opposite level is used when it lags.
    function automatic tri_drv_t drive_for(pd_state_e s, logic lead_high);
        tri_drv_t d;
        d = '0;
        case (s)
            PD_UP: begin d.oe = 1'b1; d.drv = lead_high;  end
            PD_DN: begin d.oe = 1'b1; d.drv = ~lead_high; end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pd_edge_det.sv
`timescale 1ns/1ps
module pd_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] lvl_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) lvl_q[g] <= 1'b0;
            else     lvl_q[g] <= lvl[g];
        end
        assign rise[g] = lvl[g] & ~lvl_q[g];

        // R11: a level already high on the previous edge cannot raise a new edge
        assert_no_level_retrigger_R11: assert property (@(posedge clk) disable iff (rst)
            ($past(lvl[g]) && lvl[g]) |-> !rise[g]);
    end
endmodule

// File: rtl/pd_core.sv
`timescale 1ns/1ps
module pd_core
    import pfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fr_rise,
    input  logic      fn_rise,
    output pd_state_e state,
    output logic      resolve
);
    pd_state_e st_q, st_n;
    logic      up_n, dn_n;

    always_comb begin
        up_n    = (st_q == PD_UP) || fr_rise;
        dn_n    = (st_q == PD_DN) || fn_rise;
        resolve = up_n && dn_n;
        if (resolve)   st_n = PD_IDLE;
        else if (up_n) st_n = PD_UP;
        else if (dn_n) st_n = PD_DN;
        else           st_n = PD_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= PD_IDLE;
        else     st_q <= st_n;
    end

    assign state = st_q;

    assert_never_both_R4: assert property (@(posedge clk) disable iff (rst)
        state != pd_state_e'(2'b11));

    assert_opposite_edge_ends_R4: assert property (@(posedge clk) disable iff (rst)
        (state == PD_UP && fn_rise) |=> state == PD_IDLE);

    assert_up_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (state == PD_UP && !fn_rise) |=> state == PD_UP);

    assert_dn_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (state == PD_DN && !fr_rise) |=> state == PD_DN);
endmodule

// File: rtl/pd_lock_filt.sv
`timescale 1ns/1ps
module pd_lock_filt #(
    parameter int ERR_THRESH  = 4,
    parameter int LOCK_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic resolve,
    output logic lock_ok
);
    localparam int WW = $clog2(ERR_THRESH + 1);
    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [WW-1:0] W_MAX = WW'(ERR_THRESH);
    localparam logic [CW-1:0] C_MAX = CW'(LOCK_CYCLES);

    logic [WW-1:0] width_q;
    logic [CW-1:0] good_q;
    logic [WW:0]   width_now;
    logic          too_wide;

    assign width_now = {1'b0, width_q} + {{WW{1'b0}}, active};
    assign too_wide  = width_now >= {1'b0, W_MAX};

    always_ff @(posedge clk) begin
        if (rst) begin
            width_q <= '0;
        end else if (resolve) begin
            width_q <= '0;
        end else if (active && width_q < W_MAX) begin
            width_q <= width_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            good_q <= '0;
        end else if (too_wide) begin
            good_q <= '0;
        end else if (resolve && good_q < C_MAX) begin
            good_q <= good_q + 1'b1;
        end
    end

    assign lock_ok = (good_q == C_MAX);

    assert_wide_error_drops_R10: assert property (@(posedge clk) disable iff (rst)
        (active && too_wide) |=> !lock_ok);

    assert_lock_on_compare_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_ok) |-> $past(resolve));
endmodule

// File: rtl/phase_det_lock.sv
`timescale 1ns/1ps
module phase_det_lock
    import pfd_pkg::*;
#(
    parameter int ERR_THRESH     = 4,
    parameter int LOCK_CYCLES    = 3,
    parameter bit LOCK_FILTER_EN = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic fr_in,
    input  logic fn_in,
    output logic pda_drv,
    output logic pda_oe,
    output logic pdp_drv,
    output logic pdp_oe,
    output logic ldt,
    output logic lock_ok
);
    logic [1:0] edges;
    pd_state_e  st;
    logic       resolve;
    tri_drv_t   drv_a, drv_p;

    pd_edge_det #(.N(2)) i_edge (
        .clk (clk),
        .rst (rst),
        .lvl ({fn_in, fr_in}),
        .rise(edges)
    );

    pd_core i_core (
        .clk    (clk),
        .rst    (rst),
        .fr_rise(edges[0]),
        .fn_rise(edges[1]),
        .state  (st),
        .resolve(resolve)
    );

    assign drv_p   = drive_for(st, 1'b1);
    assign drv_a   = drive_for(st, 1'b0);
    assign pdp_drv = drv_p.drv;
    assign pdp_oe  = drv_p.oe;
    assign pda_drv = drv_a.drv;
    assign pda_oe  = drv_a.oe;
    assign ldt     = (st == PD_IDLE);

    if (LOCK_FILTER_EN) begin : g_filt
        pd_lock_filt #(.ERR_THRESH(ERR_THRESH), .LOCK_CYCLES(LOCK_CYCLES)) i_filt (
            .clk    (clk),
            .rst    (rst),
            .active (!ldt),
            .resolve(resolve),
            .lock_ok(lock_ok)
        );
    end else begin : g_nofilt
        assign lock_ok = 1'b0;
    end

    assert_enables_match_R7: assert property (@(posedge clk) disable iff (rst)
        pda_oe == pdp_oe);

    assert_float_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !pda_oe |-> (!pda_drv && !pdp_drv));

    assert_opposite_sense_R3: assert property (@(posedge clk) disable iff (rst)
        pda_oe |-> (pda_drv != pdp_drv));

    assert_ldt_tracks_error_R8: assert property (@(posedge clk) disable iff (rst)
        ldt == !pdp_oe);

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (ldt && !pda_oe && !lock_ok));
endmodule

// File: tb/test_phase_det_lock.sv
`timescale 1ns/1ps
module test_phase_det_lock;
    localparam int THR  = 4;
    localparam int LOCK = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fr_in = 1'b0, fn_in = 1'b0;
    logic pda_drv, pda_oe, pdp_drv, pdp_oe, ldt, lock_ok;
    int   n_tests = 0, n_fail = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    phase_det_lock #(.ERR_THRESH(THR), .LOCK_CYCLES(LOCK)) i_phase_det_lock (
        .clk(clk), .rst(rst), .fr_in(fr_in), .fn_in(fn_in),
        .pda_drv(pda_drv), .pda_oe(pda_oe), .pdp_drv(pdp_drv), .pdp_oe(pdp_oe),
        .ldt(ldt), .lock_ok(lock_ok)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Packed {pda_oe, pda_drv, pdp_oe, pdp_drv, ldt}; mode 0 idle, 1 ref leads, 2 ref lags
    function automatic int expect_pins(int mode);
        case (mode)
            1: return 5'b10110;
            2: return 5'b11100;
            default: return 5'b00001;
        endcase
    endfunction

    function automatic int pins();
        return {27'd0, pda_oe, pda_drv, pdp_oe, pdp_drv, ldt};
    endfunction

    task automatic t_reset();
        rst = 1'b1; fr_in = 1'b0; fn_in = 1'b0;
        tick(); tick();
        chk("R1 pins in reset", pins(), expect_pins(0));
        chk("R1 lock in reset", int'(lock_ok), 0);
        rst = 1'b0;
        tick();
        chk("R1 pins after release", pins(), expect_pins(0));
    endtask

    // One comparison: leader edge, error of w cycles, follower edge
    task automatic t_pulse(bit ref_first, int w, string req);
        int mode;
        mode = ref_first ? 1 : 2;
        if (ref_first) fr_in = 1'b1; else fn_in = 1'b1;
        tick();
        chk(req, pins(), expect_pins(mode));
        fr_in = 1'b0; fn_in = 1'b0;
        for (int i = 1; i < w; i++) begin
            tick();
            chk(req, pins(), expect_pins(mode));
        end
        if (ref_first) fn_in = 1'b1; else fr_in = 1'b1;
        tick();
        chk({req, " R4 end"}, pins(), expect_pins(0));
        fr_in = 1'b0; fn_in = 1'b0;
        tick();
        chk({req, " R4 stays idle"}, pins(), expect_pins(0));
    endtask

    task automatic t_coincident();
        fr_in = 1'b1; fn_in = 1'b1;
        tick();
        chk("R5 coincident edges", pins(), expect_pins(0));
        fr_in = 1'b0; fn_in = 1'b0;
        tick();
        chk("R5 after coincident", pins(), expect_pins(0));
    endtask

    task automatic t_retrigger();
        fr_in = 1'b1; tick();
        fr_in = 1'b0; tick();
        fr_in = 1'b1; tick();
        chk("R6 second ref edge", pins(), expect_pins(1));
        fr_in = 1'b0; tick();
        fn_in = 1'b1; tick();
        chk("R6 single fb edge ends", pins(), expect_pins(0));
        fn_in = 1'b0; tick();
        chk("R6 no stale error", pins(), expect_pins(0));
    endtask

    task automatic t_held();
        fr_in = 1'b1; tick();
        tick(); tick();
        chk("R11 held ref keeps one error", pins(), expect_pins(1));
        fn_in = 1'b1; tick();
        chk("R11 resolved", pins(), expect_pins(0));
        tick(); tick();
        chk("R11 held levels no new error", pins(), expect_pins(0));
        fr_in = 1'b0; fn_in = 1'b0; tick();
    endtask

    task automatic t_lock_build();
        for (int k = 1; k <= LOCK; k++) begin
            t_pulse(k % 2 == 1, 2, "R9 short error");
            chk("R9 lock count", int'(lock_ok), (k == LOCK) ? 1 : 0);
        end
        t_pulse(1'b1, THR - 1, "R9 width below threshold");
        chk("R9 lock kept at THR-1", int'(lock_ok), 1);
    endtask

    task automatic t_lock_long();
        fn_in = 1'b1; tick();
        chk("R10 lock during error start", int'(lock_ok), 1);
        fn_in = 1'b0;
        for (int i = 1; i < THR; i++) tick();
        chk("R10 lock before threshold", int'(lock_ok), 1);
        tick();
        chk("R10 lock drops at threshold", int'(lock_ok), 0);
        chk("R10 error still pending", pins(), expect_pins(2));
        fr_in = 1'b1; tick();
        fr_in = 1'b0; tick();
        chk("R10 no relock after wide", int'(lock_ok), 0);
    endtask

    task automatic t_lock_coincident();
        for (int k = 1; k <= LOCK; k++) t_coincident();
        chk("R9 R5 coincident compares lock", int'(lock_ok), 1);
        t_pulse(1'b1, THR, "R10 width at threshold");
        chk("R10 exact threshold unlocks", int'(lock_ok), 0);
    endtask

    initial begin
        t_reset();
        t_pulse(1'b1, 3, "R2 ref leads");
        t_pulse(1'b0, 2, "R3 ref lags");
        t_pulse(1'b1, 1, "R4 one-cycle error");
        t_coincident();
        t_retrigger();
        t_held();
        t_reset();
        t_lock_build();
        t_lock_long();
        t_lock_coincident();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R1-independent: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule